// File: doc/BRIEF.md
# Super I/O Configuration Port Controller

This block provides a two-port configuration window of the kind a legacy Super I/O controller offers on a byte-wide host bus. The host uses one address bit to choose between an index port (address bit 0, which sits at I/O address 0x2E in a PC map) and a data port (address bit 1, which sits at 0x2F). A write or read strobe then moves one byte. Until a fixed four-byte key reaches the index port, the window stays locked. Data reads return 0xFF and data writes do nothing.

Once the window is unlocked, each index write selects a register and data accesses read or write it. Three global read-only registers identify the chip. A device-number register at index 0x07 chooses which bank of per-device registers the data port reaches. The device banks sit in a window of `WIN` registers that starts at `WIN_BASE`. Their contents go out on a flat bus to sibling logic. When the exit command is written, the window locks again.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the window is locked (`cfg_mode`=0), `ldn_out` is 0, every device register is 0 and `bus_rdata` is 0.
- R2: Index-port writes of 0x87, 0x01, 0x55, 0x55, in that order, set `cfg_mode` to 1 from the cycle after the last write.
- R3: A byte that breaks the key sequence resets the matcher, so the full key must be written again. A breaking byte equal to 0x87 counts as the first key byte, so that 0x87 0x01 0x87 0x01 0x55 0x55 unlocks.
- R4: While the window is locked, data-port writes change neither `ldn_out` nor any device register, and reads of either port return 0xFF.
- R5: Reading the data port returns `CHIP_ID[15:8]` when the index is 0x20, `CHIP_ID[7:0]` when the index is 0x21, and `CHIP_REV` (revision in bits 3:0) when the index is 0x22.
- R6: Data writes to indices 0x20, 0x21 and 0x22 are discarded.
- R7: Index 0x07 holds the device number. It is writable and reads back, and its value is driven on `ldn_out`.
- R8: A data write to index `WIN_BASE+k` (k < `WIN`) stores the byte in register k of device `ldn_out`. That byte appears on `dev_cfg_flat[(ldn*WIN+k)*8 +: 8]` and reads back only while the same device is selected.
- R9: Writing 0x02 to the index port and then 0x02 to the data port locks the window. Any other data value written at index 0x02 leaves the window unlocked.
- R10: `bus_rdata` takes the addressed value on the clock edge that samples `bus_rd`. Once unlocked, an index-port read returns the current index.
- R11: When the device number is `NUM_DEV` or larger, window writes are discarded and window reads return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_sel | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, registered |
| cfg_mode | output | 1 | 1 while the window is unlocked |
| ldn_out | output | 8 | Selected device number |
| dev_cfg_flat | output | NUM_DEV*WIN*8 | All device register bytes, device-major |

## Verification
Every write takes effect on the edge that samples its strobe. So `cfg_mode`, `ldn_out` and `dev_cfg_flat` are checked at the falling edge after that edge. A read result is registered on the edge that samples `bus_rd`. The driver queues the expected byte when it raises the strobe. The monitor pops that byte and compares it 1 ns after the sampling edge, so each compare lines up with exactly one strobe. A non-empty queue at the end of the run counts as a mismatch.

// File: rtl/sio_cfg_pkg.sv
// Shared constants for the configuration port: key bytes, fixed register
// indices and exit command. Assumes an 8-bit host data path.
package sio_cfg_pkg;
    localparam int KEY_LEN = 4;
    localparam int KEY_W   = $clog2(KEY_LEN);

    localparam logic [7:0] IDX_EXIT  = 8'h02;
    localparam logic [7:0] VAL_EXIT  = 8'h02;
    localparam logic [7:0] IDX_LDN   = 8'h07;
    localparam logic [7:0] IDX_ID_HI = 8'h20;
    localparam logic [7:0] IDX_ID_LO = 8'h21;
    localparam logic [7:0] IDX_REV   = 8'h22;
    localparam logic [7:0] LOCK_READ = 8'hFF;

    // Returns the expected key byte for a given match position.
    function automatic logic [7:0] key_byte(input logic [KEY_W-1:0] pos);
        case (pos)
            2'd0:    key_byte = 8'h87;
            2'd1:    key_byte = 8'h01;
            default: key_byte = 8'h55;
        endcase
    endfunction
endpackage

// File: rtl/sio_unlock_fsm.sv
// Key matcher and lock state. Watches index-port writes while locked and
// unlocks after the full key; relocks on an exit request from the decoder.
// Assumes key_wr and exit_req are single-cycle qualified strobes.
module sio_unlock_fsm
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    input  logic       exit_req,
    output logic       unlocked
);
    logic [KEY_W-1:0] step_q;
    logic             last_step;

    assign last_step = (step_q == KEY_W'(KEY_LEN - 1));

    // Advance, restart or clear the matcher and hold the lock state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q   <= '0;
            unlocked <= 1'b0;
        end else if (unlocked) begin
            step_q <= '0;
            if (exit_req) unlocked <= 1'b0;
        end else if (key_wr) begin
            if (key_data == key_byte(step_q)) begin
                if (last_step) begin
                    unlocked <= 1'b1;
                    step_q   <= '0;
                end else begin
                    step_q <= step_q + KEY_W'(1);
                end
            end else if (key_data == key_byte('0)) begin
                step_q <= KEY_W'(1);
            end else begin
                step_q <= '0;
            end
        end
    end
endmodule

// File: rtl/sio_dev_bank.sv
// Per-device register storage: NUM_DEV banks of WIN bytes, written one byte
// at a time. Assumes dev_sel and reg_sel are in range whenever wr_en is high.
module sio_dev_bank #(
    parameter int NUM_DEV = 4,
    parameter int WIN     = 16,
    localparam int DEV_W  = $clog2(NUM_DEV),
    localparam int REG_W  = $clog2(WIN)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [DEV_W-1:0]          dev_sel,
    input  logic [REG_W-1:0]          reg_sel,
    input  logic [7:0]                wdata,
    output logic [NUM_DEV*WIN*8-1:0]  regs_flat
);
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        for (genvar r = 0; r < WIN; r++) begin : g_reg
            logic [7:0] byte_q;
            // Store one device register byte when addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    byte_q <= 8'h00;
                else if (wr_en && dev_sel == DEV_W'(d) && reg_sel == REG_W'(r))
                    byte_q <= wdata;
            end
            assign regs_flat[(d*WIN + r)*8 +: 8] = byte_q;
        end
    end
endmodule

// File: rtl/sio_cfg_port.sv
// Index/data configuration port. Decodes host strobes, holds the index and
// device-number registers, returns registered read data and exports all
// device banks. Assumes bus_wr and bus_rd are never high in the same cycle.
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int          NUM_DEV  = 4,
    parameter int          WIN      = 16,
    parameter logic [7:0]  WIN_BASE = 8'h70,
    parameter logic [15:0] CHIP_ID  = 16'h8A5C,
    parameter logic [7:0]  CHIP_REV = 8'h03
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic                      bus_sel,
    input  logic [7:0]                bus_wdata,
    output logic [7:0]                bus_rdata,
    output logic                      cfg_mode,
    output logic [7:0]                ldn_out,
    output logic [NUM_DEV*WIN*8-1:0]  dev_cfg_flat
);
    localparam int DEV_W = $clog2(NUM_DEV);
    localparam int REG_W = $clog2(WIN);

    logic [7:0] index_q;
    logic [7:0] ldn_q;
    logic [7:0] win_off;
    logic       in_win;
    logic       ldn_ok;
    logic       idx_wr;
    logic       data_wr;
    logic       exit_req;
    logic       bank_wr;
    logic [7:0] rd_val;

    assign idx_wr   = bus_wr && !bus_sel;
    assign data_wr  = bus_wr && bus_sel && cfg_mode;
    assign win_off  = index_q - WIN_BASE;
    assign in_win   = (win_off < 8'(WIN));
    assign ldn_ok   = (ldn_q < 8'(NUM_DEV));
    assign exit_req = data_wr && index_q == IDX_EXIT && bus_wdata == VAL_EXIT;
    assign bank_wr  = data_wr && in_win && ldn_ok;
    assign ldn_out  = ldn_q;

    sio_unlock_fsm u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (idx_wr),
        .key_data (bus_wdata),
        .exit_req (exit_req),
        .unlocked (cfg_mode)
    );

    sio_dev_bank #(.NUM_DEV(NUM_DEV), .WIN(WIN)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bank_wr),
        .dev_sel   (ldn_q[DEV_W-1:0]),
        .reg_sel   (win_off[REG_W-1:0]),
        .wdata     (bus_wdata),
        .regs_flat (dev_cfg_flat)
    );

    // Capture the register index on unlocked index-port writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                  index_q <= 8'h00;
        else if (idx_wr && cfg_mode) index_q <= bus_wdata;
    end

    // Capture the device number on data writes to its index.
    always_ff @(posedge clk) begin
        if (!rst_n)                            ldn_q <= 8'h00;
        else if (data_wr && index_q == IDX_LDN) ldn_q <= bus_wdata;
    end

    // Select the byte that a data-port read returns while unlocked.
    always_comb begin
        rd_val = 8'h00;
        if (in_win)
            rd_val = ldn_ok ? dev_cfg_flat[(int'(ldn_q[DEV_W-1:0])*WIN
                                            + int'(win_off[REG_W-1:0]))*8 +: 8]
                            : LOCK_READ;
        else begin
            case (index_q)
                IDX_LDN:   rd_val = ldn_q;
                IDX_ID_HI: rd_val = CHIP_ID[15:8];
                IDX_ID_LO: rd_val = CHIP_ID[7:0];
                IDX_REV:   rd_val = CHIP_REV;
                default:   rd_val = 8'h00;
            endcase
        end
    end

    // Register the read result on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         bus_rdata <= 8'h00;
        else if (bus_rd) begin
            if (!cfg_mode)    bus_rdata <= LOCK_READ;
            else if (bus_sel) bus_rdata <= rd_val;
            else              bus_rdata <= index_q;
        end
    end
endmodule

// File: rtl/sio_cfg_port_chk.sv
// Property checker for sio_cfg_port, attached by bind. Observes ports and
// the index register; drives nothing.
module sio_cfg_port_chk #(
    parameter int          NUM_DEV = 4,
    parameter int          WIN     = 16,
    parameter logic [15:0] CHIP_ID = 16'h8A5C
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_wr,
    input logic                     bus_rd,
    input logic                     bus_sel,
    input logic [7:0]               bus_wdata,
    input logic [7:0]               bus_rdata,
    input logic                     cfg_mode,
    input logic [7:0]               ldn_out,
    input logic [NUM_DEV*WIN*8-1:0] dev_cfg_flat,
    input logic [7:0]               index_q
);
    assert_unlock_by_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_mode) |-> $past(bus_wr && !bus_sel && bus_wdata == 8'h55));

    assert_locked_read_ff_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !cfg_mode) |=> bus_rdata == 8'hFF);

    assert_locked_banks_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |=> $stable(dev_cfg_flat));

    assert_locked_ldn_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |=> $stable(ldn_out));

    assert_id_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && bus_rd && bus_sel && index_q == 8'h20) |=> bus_rdata == CHIP_ID[15:8]);

    assert_exit_locks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && bus_wr && bus_sel && index_q == 8'h02 && bus_wdata == 8'h02)
        |=> !cfg_mode);
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.NUM_DEV(NUM_DEV), .WIN(WIN), .CHIP_ID(CHIP_ID)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_sel      (bus_sel),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .cfg_mode     (cfg_mode),
    .ldn_out      (ldn_out),
    .dev_cfg_flat (dev_cfg_flat),
    .index_q      (index_q)
);

// File: tb/sio_cfg_port_test.sv
`timescale 1ns/1ps
module sio_cfg_port_test;
    localparam int NUM_DEV = 4;
    localparam int WIN     = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic cfg_mode;
    logic [7:0] ldn_out;
    logic [NUM_DEV*WIN*8-1:0] dev_cfg_flat;

    int compared = 0;
    int mismatched = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] model [NUM_DEV][WIN];

    always #2 clk = ~clk;

    sio_cfg_port #(.NUM_DEV(NUM_DEV), .WIN(WIN), .WIN_BASE(8'h70),
                   .CHIP_ID(16'h8A5C), .CHIP_REV(8'h03)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_mode(cfg_mode), .ldn_out(ldn_out), .dev_cfg_flat(dev_cfg_flat));

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_sel = sel;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic check_banks(input string tag);
        for (int d = 0; d < NUM_DEV; d++)
            for (int r = 0; r < WIN; r++)
                check(tag, dev_cfg_flat[(d*WIN + r)*8 +: 8], model[d][r]);
    endtask

    task automatic send_key();
        wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h55); wr(0, 8'h55);
    endtask

    // Monitor: pops one expected byte for each sampled read strobe.
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                #1;
                if (exp_q.size() == 0) begin
                    compared++; mismatched++;
                    $display("FAIL R10: read with no expected item, got %02h expected none", bus_rdata);
                end else
                    check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #200000;
        compared++; mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int d = 0; d < NUM_DEV; d++)
            for (int r = 0; r < WIN; r++) model[d][r] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 cfg_mode", {7'd0, cfg_mode}, 8'h00);
        check("R1 ldn", ldn_out, 8'h00);
        check("R1 rdata", bus_rdata, 8'h00);
        check_banks("R1 banks");
        // R4: locked accesses
        rd(1, 8'hFF, "R4 locked data read");
        rd(0, 8'hFF, "R4 locked index read");
        wr(0, 8'h07); wr(1, 8'h03);
        check("R4 ldn untouched", ldn_out, 8'h00);
        wr(0, 8'h72); wr(1, 8'h5A);
        check_banks("R4 banks untouched");
        // R3: broken key then plain key stays locked until full
        wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h55); wr(0, 8'hAA);
        wr(0, 8'h55);
        check("R3 broken key locked", {7'd0, cfg_mode}, 8'h00);
        // R2: full key unlocks
        send_key();
        check("R2 unlocked", {7'd0, cfg_mode}, 8'h01);
        // R9: wrong exit value keeps unlocked, right one locks
        wr(0, 8'h02); wr(1, 8'h05);
        check("R9 wrong exit", {7'd0, cfg_mode}, 8'h01);
        wr(1, 8'h02);
        check("R9 exit", {7'd0, cfg_mode}, 8'h00);
        // R3: 0x87 restarts at step two
        wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h55); wr(0, 8'h55);
        check("R3 restart unlocks", {7'd0, cfg_mode}, 8'h01);
        // R10 / R5: index read and ID registers
        wr(0, 8'h20);
        rd(0, 8'h20, "R10 index read");
        rd(1, 8'h8A, "R5 id high");
        wr(0, 8'h21); rd(1, 8'h5C, "R5 id low");
        wr(0, 8'h22); rd(1, 8'h03, "R5 revision");
        // R6: read-only ID
        wr(0, 8'h20); wr(1, 8'h00); rd(1, 8'h8A, "R6 id high kept");
        wr(0, 8'h22); wr(1, 8'hF0); rd(1, 8'h03, "R6 revision kept");
        // R7: device number
        wr(0, 8'h07); wr(1, 8'h02);
        check("R7 ldn out", ldn_out, 8'h02);
        rd(1, 8'h02, "R7 ldn readback");
        // R8: banked window
        wr(0, 8'h73); wr(1, 8'hA5); model[2][3] = 8'hA5;
        check_banks("R8 dev2 write");
        rd(1, 8'hA5, "R8 dev2 readback");
        wr(0, 8'h07); wr(1, 8'h01);
        wr(0, 8'h73); rd(1, 8'h00, "R8 dev1 separate");
        wr(1, 8'h3C); model[1][3] = 8'h3C;
        wr(0, 8'h7F); wr(1, 8'hC3); model[1][15] = 8'hC3;
        check_banks("R8 dev1 writes");
        rd(1, 8'hC3, "R8 last window reg");
        // R11: out-of-range device
        wr(0, 8'h07); wr(1, 8'h09);
        wr(0, 8'h73); wr(1, 8'h11);
        check_banks("R11 write dropped");
        rd(1, 8'hFF, "R11 read ff");
        // R9 / R4: exit then locked reads
        wr(0, 8'h02); wr(1, 8'h02);
        check("R9 exit again", {7'd0, cfg_mode}, 8'h00);
        check("R4 ldn retained", ldn_out, 8'h09);
        rd(1, 8'hFF, "R4 locked data read after exit");
        rd(0, 8'hFF, "R4 locked index read after exit");
        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            compared++; mismatched++;
            $display("FAIL R10: pending reads got %0d expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule